// File: doc/BRIEF.md
# Two-Stage Parallel Code Register for a 12-Bit Converter

This block is the digital front end of a 12-bit parallel-input converter, modelled in a single clock domain. A host writes a code into a holding register in two independently selected lanes: a low lane of eight bits and a high lane of four bits. A shared active-low write strobe qualifies the two active-low lane selects. A separate active-low load strobe then moves the holding register into the code register, which drives the converter code output. Because of this double buffering, a full 12-bit code can be assembled from two partial writes and applied to the output in a single step.

All strobes are asynchronous to the clock. They pass through a synchronizer chain. The data bus goes through a delay line of the same depth, so that data and strobes stay aligned. Each stage acts as an emulated level-sensitive latch: it follows its input on every clock while its enable holds, and it keeps its value once the enable drops. When write, both selects and load are low together, both stages are open and the data bus reaches the code output. An active-low clear and the power-on reset zero both registers asynchronously. The clear overrides every strobe.

Top module: `dac_dbuf_front`

## Requirements
- R1: After power-on reset (`rst_n` low), `code` reads 0 and the holding register also holds 0.
- R2: With `wr_n` and `sel_lo_n` low and `sel_hi_n` high, only holding bits 7:0 take `din[7:0]`; bits 11:8 keep their value.
- R3: With `wr_n` and `sel_hi_n` low and `sel_lo_n` high, only holding bits 11:8 take `din[11:8]`; bits 7:0 keep their value.
- R4: With `wr_n`, `sel_lo_n` and `sel_hi_n` all low, all 12 holding bits take `din`.
- R5: A lane select without `wr_n`, or `wr_n` without a lane select, leaves the holding register unchanged.
- R6: After a strobe rises, later changes on `din` are not captured: the stage holds the value present at the release.
- R7: While `ld_n` is low, `code` takes the holding register. While `ld_n` is high, `code` is unchanged, even when writes take place.
- R8: With all four strobes low, `code` follows `din`. A change on `din` appears on `code` exactly SYNC_STAGES+1 rising clock edges later.
- R9: While `clr_n` is low, `code` and the holding register are 0, regardless of the strobes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock sampling the strobes |
| rst_n | input | 1 | Active-low power-on reset of all state |
| clr_n | input | 1 | Active-low asynchronous clear of both registers |
| wr_n | input | 1 | Active-low write strobe shared by both lanes |
| sel_lo_n | input | 1 | Active-low select of the low lane (bits 7:0) |
| sel_hi_n | input | 1 | Active-low select of the high lane (bits 11:8) |
| ld_n | input | 1 | Active-low transfer strobe into the code register |
| din | input | LO_W+HI_W | Parallel data bus |
| code | output | LO_W+HI_W | Code register output to the converter |

## Verification
The bench builds the block with its defaults: an 8-bit low lane, a 4-bit high lane and a two-stage synchronizer. With these values a three-edge transparent latency can be checked to the exact cycle. The split at bit 8 can be seen by loading patterns whose two lanes differ. A reference model, kept apart from the design, follows the holding register and the code register through partial writes, held data, loads and a clear applied while every strobe is low.

// File: rtl/dacfe_pkg.sv
package dacfe_pkg;

  typedef struct packed {
    logic wr_n;
    logic lo_n;
    logic hi_n;
    logic ld_n;
  } strobe_t;

  typedef struct packed {
    logic lo_en;
    logic hi_en;
    logic ld_en;
  } enables_t;

  function automatic enables_t decode_strobes(input strobe_t s);
    enables_t e;
    e.lo_en = !s.wr_n && !s.lo_n;
    e.hi_en = !s.wr_n && !s.hi_n;
    e.ld_en = !s.ld_n;
    return e;
  endfunction

endpackage

// File: rtl/dacfe_pipe.sv
module dacfe_pipe #(
  parameter int W = 4,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] st [STAGES];

  genvar i;
  generate
    for (i = 0; i < STAGES; i++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st[i] <= RST_VAL;
        else if (i == 0) st[i] <= d;
        else st[i] <= st[(i == 0) ? 0 : i-1];
      end
    end
  endgenerate

  assign q = st[STAGES-1];
endmodule

// File: rtl/dacfe_inreg.sv
module dacfe_inreg #(
  parameter int LO_W = 8,
  parameter int HI_W = 4
) (
  input  logic                 clk,
  input  logic                 arst_n,
  input  logic                 lo_en,
  input  logic                 hi_en,
  input  logic [LO_W+HI_W-1:0] d,
  output logic [LO_W+HI_W-1:0] q,
  output logic [LO_W+HI_W-1:0] nxt
);
  localparam int DW = LO_W + HI_W;

  genvar ln;
  generate
    for (ln = 0; ln < 2; ln++) begin : g_lane
      localparam int LSB = (ln == 0) ? 0 : LO_W;
      localparam int LW  = (ln == 0) ? LO_W : HI_W;
      logic en;
      assign en = (ln == 0) ? lo_en : hi_en;
      assign nxt[LSB +: LW] = en ? d[LSB +: LW] : q[LSB +: LW];
      always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) q[LSB +: LW] <= '0;
        else q[LSB +: LW] <= nxt[LSB +: LW];
      end
    end
  endgenerate

  logic [DW-1:0] unused_w;
  assign unused_w = '0;
endmodule

// File: rtl/dacfe_outreg.sv
module dacfe_outreg #(
  parameter int DW = 12
) (
  input  logic          clk,
  input  logic          arst_n,
  input  logic          ld_en,
  input  logic [DW-1:0] d,
  output logic [DW-1:0] q
);
  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) q <= '0;
    else if (ld_en) q <= d;
  end
endmodule

// File: rtl/dac_dbuf_front.sv
module dac_dbuf_front
  import dacfe_pkg::*;
#(
  parameter int LO_W = 8,
  parameter int HI_W = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 clr_n,
  input  logic                 wr_n,
  input  logic                 sel_lo_n,
  input  logic                 sel_hi_n,
  input  logic                 ld_n,
  input  logic [LO_W+HI_W-1:0] din,
  output logic [LO_W+HI_W-1:0] code
);
  localparam int DW = LO_W + HI_W;
  localparam int SW = $bits(strobe_t);

  strobe_t       strb_raw, strb_s;
  enables_t      en;
  logic [DW-1:0] din_d;
  logic [DW-1:0] in_q;
  logic [DW-1:0] in_nxt;
  logic          arst_n;
  logic          wr_lo_en, wr_hi_en, ld_en;

  assign strb_raw = '{wr_n: wr_n, lo_n: sel_lo_n, hi_n: sel_hi_n, ld_n: ld_n};
  assign arst_n   = rst_n & clr_n;

  dacfe_pipe #(.W(SW), .STAGES(SYNC_STAGES), .RST_VAL({SW{1'b1}})) u_sync (
    .clk(clk), .rst_n(rst_n), .d(strb_raw), .q(strb_s)
  );

  dacfe_pipe #(.W(DW), .STAGES(SYNC_STAGES), .RST_VAL('0)) u_dly (
    .clk(clk), .rst_n(rst_n), .d(din), .q(din_d)
  );

  assign en       = decode_strobes(strb_s);
  assign wr_lo_en = en.lo_en;
  assign wr_hi_en = en.hi_en;
  assign ld_en    = en.ld_en;

  dacfe_inreg #(.LO_W(LO_W), .HI_W(HI_W)) u_in (
    .clk(clk), .arst_n(arst_n), .lo_en(wr_lo_en), .hi_en(wr_hi_en),
    .d(din_d), .q(in_q), .nxt(in_nxt)
  );

  dacfe_outreg #(.DW(DW)) u_out (
    .clk(clk), .arst_n(arst_n), .ld_en(ld_en), .d(in_nxt), .q(code)
  );
endmodule

// File: rtl/dacfe_chk.sv
module dacfe_chk #(
  parameter int LO_W = 8,
  parameter int HI_W = 4
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 clr_n,
  input logic                 wr_lo_en,
  input logic                 wr_hi_en,
  input logic                 ld_en,
  input logic [LO_W+HI_W-1:0] in_q,
  input logic [LO_W+HI_W-1:0] din_d,
  input logic [LO_W+HI_W-1:0] code
);
  localparam int DW = LO_W + HI_W;

  a_r2_lo_only_keeps_hi: assert property (@(posedge clk) disable iff (!rst_n || !clr_n)
    (wr_lo_en && !wr_hi_en) |=> $stable(in_q[DW-1:LO_W]));

  a_r3_hi_only_keeps_lo: assert property (@(posedge clk) disable iff (!rst_n || !clr_n)
    (wr_hi_en && !wr_lo_en) |=> $stable(in_q[LO_W-1:0]));

  a_r5_no_write_holds: assert property (@(posedge clk) disable iff (!rst_n || !clr_n)
    (!wr_lo_en && !wr_hi_en) |=> $stable(in_q));

  a_r7_no_load_holds: assert property (@(posedge clk) disable iff (!rst_n || !clr_n)
    !ld_en |=> $stable(code));

  a_r8_transparent_path: assert property (@(posedge clk) disable iff (!rst_n || !clr_n)
    (ld_en && wr_lo_en && wr_hi_en) |=> (code == $past(din_d)));

  a_r9_clear_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_n |-> (code == '0 && in_q == '0));
endmodule

bind dac_dbuf_front dacfe_chk #(.LO_W(LO_W), .HI_W(HI_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .clr_n(clr_n), .wr_lo_en(wr_lo_en),
  .wr_hi_en(wr_hi_en), .ld_en(ld_en), .in_q(in_q), .din_d(din_d), .code(code)
);

// File: tb/dac_dbuf_front_test.sv
module dac_dbuf_front_test;
  localparam int CLK_PERIOD = 10;
  localparam int LO_W = 8;
  localparam int HI_W = 4;
  localparam int SYNC = 2;
  localparam int DW = LO_W + HI_W;

  logic clk = 0, rst_n = 0, clr_n = 1;
  logic wr_n = 1, sel_lo_n = 1, sel_hi_n = 1, ld_n = 1;
  logic [DW-1:0] din = '0;
  logic [DW-1:0] code;

  logic [DW-1:0] ref_in = '0;
  logic [DW-1:0] ref_code = '0;
  int checks = 0, errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dac_dbuf_front #(.LO_W(LO_W), .HI_W(HI_W), .SYNC_STAGES(SYNC)) uut (
    .clk(clk), .rst_n(rst_n), .clr_n(clr_n), .wr_n(wr_n), .sel_lo_n(sel_lo_n),
    .sel_hi_n(sel_hi_n), .ld_n(ld_n), .din(din), .code(code)
  );

  task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: code=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Apply strobes, release them, then scramble din to prove it is held (R6).
  task automatic strobe(input logic w, input logic lo, input logic hi, input logic ld,
                        input logic [DW-1:0] d);
    @(negedge clk);
    din = d; wr_n = w; sel_lo_n = lo; sel_hi_n = hi; ld_n = ld;
    idle(4);
    wr_n = 1; sel_lo_n = 1; sel_hi_n = 1; ld_n = 1;
    idle(1);
    din = ~d;
    idle(SYNC + 3);
  endtask

  task automatic do_load;
    strobe(1, 1, 1, 0, din);
    ref_code = ref_in;
  endtask

  task automatic t_reset;
    check("R1 code after reset", code, '0);
    do_load();
    check("R1 holding register after reset", code, '0);
  endtask

  task automatic t_lo_write;
    strobe(0, 0, 1, 1, 12'hA5C);
    ref_in[7:0] = 8'h5C;
    check("R7 no load keeps code", code, ref_code);
    do_load();
    check("R2 low lane only", code, ref_in);
  endtask

  task automatic t_hi_write;
    strobe(0, 1, 0, 1, 12'h3E1);
    ref_in[11:8] = 4'h3;
    do_load();
    check("R3 high lane only", code, ref_in);
  endtask

  task automatic t_both_write;
    strobe(0, 0, 0, 1, 12'h96B);
    ref_in = 12'h96B;
    check("R7 write without load", code, ref_code);
    do_load();
    check("R4 both lanes and R6 hold", code, ref_in);
  endtask

  task automatic t_no_select;
    strobe(0, 1, 1, 1, 12'h0F0);
    strobe(1, 0, 0, 1, 12'hF0F);
    do_load();
    check("R5 incomplete strobes ignored", code, ref_in);
  endtask

  task automatic t_transparent;
    @(negedge clk);
    din = 12'h123; wr_n = 0; sel_lo_n = 0; sel_hi_n = 0; ld_n = 0;
    idle(SYNC + 2);
    check("R8 transparent first value", code, 12'h123);
    din = 12'hFED;
    idle(SYNC);
    check("R8 latency not yet", code, 12'h123);
    idle(1);
    check("R8 latency exact", code, 12'hFED);
    wr_n = 1; sel_lo_n = 1; sel_hi_n = 1; ld_n = 1;
    idle(1);
    din = 12'h000;
    idle(SYNC + 3);
    ref_in = 12'hFED; ref_code = 12'hFED;
    check("R6 transparent release holds", code, ref_code);
  endtask

  task automatic t_clear;
    @(negedge clk);
    din = 12'h7AA; wr_n = 0; sel_lo_n = 0; sel_hi_n = 0; ld_n = 0;
    idle(SYNC + 2);
    check("R8 before clear", code, 12'h7AA);
    clr_n = 0;
    #1;
    check("R9 clear is immediate", code, '0);
    idle(3);
    check("R9 clear overrides strobes", code, '0);
    wr_n = 1; sel_lo_n = 1; sel_hi_n = 1; ld_n = 1;
    idle(SYNC + 2);
    clr_n = 1;
    ref_in = '0; ref_code = '0;
    idle(2);
    do_load();
    check("R9 holding register cleared", code, '0);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: code=%h expected=run completion", code);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    idle(3);
    rst_n = 1;
    idle(2);
    t_reset();
    t_lo_write();
    t_hi_write();
    t_both_write();
    t_no_select();
    t_transparent();
    t_clear();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule